// File: doc/BRIEF.md
# Widening Vector Shift-Left Unit

This block performs an element-wise widening logical left shift on a vector operand. Each active source element is SEW bits wide. It is zero-extended to twice that width, shifted left, and stored as a destination element of 2*SEW bits. The shift count for element i is either element i of a second vector operand or one scalar value shared by every element. Only the low log2(2*SEW) bits of the count are used, so the count is taken modulo 2*SEW.

A start strobe, sampled while the unit is idle, captures a complete operation: both vector images, the scalar, the operand select, the mask, the width select, the start index, the length and the prior destination contents. The unit then walks the element indices one per clock. Elements below the start index, elements at or above the length, and masked-off elements keep their prior value. When the walk ends, the unit pulses done together with a dirty indication, and its resume-index output returns to zero. A width select of 64 is refused with an illegal flag and the destination is left unchanged.

Top module: `widen_shl`

## Requirements
- R1: Each processed source element is zero-extended to 2*SEW bits before the shift, and the full 2*SEW-bit shifted result, truncated to 2*SEW bits, replaces the destination element.
- R2: Only the low 4, 5 or 6 bits of the shift count are used for SEW of 8, 16 or 32 (count modulo 2*SEW); a count equal to 2*SEW shifts by zero.
- R3: When `useScalar`=1, every element is shifted by the 64-bit `shScalar`; when 0, element i is shifted by the SEW-wide field of `shVec` at bits [i*SEW +: SEW].
- R4: `sewSel` encodes 0 = SEW 8, 1 = SEW 16, 2 = SEW 32. Source element i sits at `srcVec`[i*SEW +: SEW], and destination element i sits at `destOut`[i*2*SEW +: 2*SEW].
- R5: Only indices from `vstartIn` to `vlIn`-1 are written. Every other destination element keeps the value from `oldDest` captured at start, and `vstartIn` >= `vlIn` leaves the whole image unchanged.
- R6: With `maskOn`=0, an element whose `maskVec` bit is 0 keeps its old destination value. With `maskOn`=1 the mask is ignored.
- R7: `sewSel`=3 is illegal. `illegal` and `done` pulse one cycle after the start edge, `dirty` stays 0, and `destOut` equals `oldDest`.
- R8: For a legal operation, `done` rises (max(0, vl-vstart)+1) clock edges after the start edge, is a single-cycle pulse, and stays 0 before that.
- R9: On legal completion `dirty` pulses with `done` and `vstartOut` is 0. Right after the start edge, `vstartOut` equals `vstartIn`.
- R10: After reset, `destOut`, `done`, `illegal`, `dirty` and `vstartOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| srcVec | input | NUM_ELEM*32 | Source vector image, SEW-packed |
| shVec | input | NUM_ELEM*32 | Shift-count vector image, SEW-packed |
| shScalar | input | 64 | Shared scalar shift count |
| useScalar | input | 1 | 1 selects the scalar count, 0 the vector count |
| maskOn | input | 1 | 1 means unmasked; 0 applies maskVec |
| maskVec | input | NUM_ELEM | Per-element enable bits |
| sewSel | input | 2 | Source element width select |
| vstartIn | input | IDX_W | First element index |
| vlIn | input | IDX_W | Element count limit (exclusive end) |
| oldDest | input | NUM_ELEM*64 | Prior destination image |
| destOut | output | NUM_ELEM*64 | Destination image |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Refused-width pulse, with done |
| dirty | output | 1 | Destination-modified pulse, with done |
| vstartOut | output | IDX_W | Resume index, zero after completion |

## Verification
The assertions take for granted that `vlIn` never exceeds NUM_ELEM, and that `start` is raised only while the unit is idle and never in the cycle where `done` is high, unless that start is meant to be a new operation. The stimulus holds `start` for exactly one cycle. It waits for each `done` plus an idle cycle before launching the next operation, and it draws lengths and start indices from 0 to NUM_ELEM only. A behavioural model predicts `done` on every clock of each operation, and also predicts the image and flags at completion.

// File: rtl/widen_shl_pkg.sv
package widen_shl_pkg;

  typedef enum logic [1:0] {
    SEW_8   = 2'd0,
    SEW_16  = 2'd1,
    SEW_32  = 2'd2,
    SEW_BAD = 2'd3
  } sewSel_e;

  typedef struct packed {
    logic load;   // capture operands and prior destination
    logic write;  // process element at current index
  } ctlStrobe_t;

endpackage

// File: rtl/widen_shl_ctrl.sv
module widen_shl_ctrl
  import widen_shl_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  localparam int IDX_W = $clog2(NUM_ELEM + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       sewSel,
  input  logic [IDX_W-1:0] vstartIn,
  input  logic [IDX_W-1:0] vlIn,
  output ctlStrobe_t       strb,
  output logic [IDX_W-1:0] idx,
  output logic             done,
  output logic             illegal,
  output logic             dirty
);

  typedef enum logic {ST_IDLE, ST_RUN} ctlState_e;

  ctlState_e        state;
  logic [IDX_W-1:0] vlR;
  logic             sewBad;

  assign sewBad = (sewSel == SEW_BAD);

  always_comb begin
    strb.load  = (state == ST_IDLE) && start;
    strb.write = (state == ST_RUN) && (idx < vlR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      vlR     <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
      dirty   <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      dirty   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (sewBad) begin
              done    <= 1'b1;
              illegal <= 1'b1;
            end else begin
              state <= ST_RUN;
              idx   <= vstartIn;
              vlR   <= vlIn;
            end
          end
        end
        default: begin
          if (idx < vlR) begin
            idx <= idx + 1'b1;
          end else begin
            state <= ST_IDLE;
            idx   <= '0;
            done  <= 1'b1;
            dirty <= 1'b1;
          end
        end
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> !done);  // R8
  AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> done && !dirty);  // R7
  AST_RESUME_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    done |-> idx == '0);  // R9
  AST_WRITE_ONLY_RUN: assert property (@(posedge clk) disable iff (!rstN)
    strb.write |-> !done);  // R8

endmodule

// File: rtl/widen_shl_dpath.sv
module widen_shl_dpath
  import widen_shl_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  localparam int IDX_W = $clog2(NUM_ELEM + 1),
  localparam int SRC_W = NUM_ELEM * 32,
  localparam int DST_W = NUM_ELEM * 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  logic [IDX_W-1:0] idx,
  input  logic [SRC_W-1:0] srcVec,
  input  logic [SRC_W-1:0] shVec,
  input  logic [63:0]      shScalar,
  input  logic             useScalar,
  input  logic             maskOn,
  input  logic [NUM_ELEM-1:0] maskVec,
  input  logic [1:0]       sewSel,
  input  logic [DST_W-1:0] oldDest,
  output logic [DST_W-1:0] destOut
);

  logic [SRC_W-1:0]    srcR, shR;
  logic [63:0]         scalarR;
  logic                useScalarR, maskOnR;
  logic [NUM_ELEM-1:0] maskR;
  logic [1:0]          sewR;

  logic [SRC_W-1:0]    srcShr, shShr;
  logic [NUM_ELEM-1:0] maskShr;
  logic [31:0]         elemMask;
  logic [5:0]          amtMask, amt;
  logic [63:0]         srcElem, amtRaw, dstMask, result;
  logic [DST_W-1:0]    fieldMask, fieldVal, destNext;
  logic                active;
  int unsigned         srcOff, dstOff;

  always_comb begin
    case (sewR)
      SEW_8:   begin elemMask = 32'h0000_00FF; amtMask = 6'd15; dstMask = 64'h0000_0000_0000_FFFF; end
      SEW_16:  begin elemMask = 32'h0000_FFFF; amtMask = 6'd31; dstMask = 64'h0000_0000_FFFF_FFFF; end
      default: begin elemMask = 32'hFFFF_FFFF; amtMask = 6'd63; dstMask = '1; end
    endcase
    srcOff  = 32'(idx) * (32'd8 << sewR);
    dstOff  = srcOff * 2;
    srcShr  = srcR >> srcOff;
    shShr   = shR >> srcOff;
    maskShr = maskR >> idx;
    active  = maskOnR | maskShr[0];
    srcElem = {32'b0, srcShr[31:0] & elemMask};
    amtRaw  = useScalarR ? scalarR : {32'b0, shShr[31:0] & elemMask};
    amt     = amtRaw[5:0] & amtMask;
    result  = (srcElem << amt) & dstMask;
    fieldMask = {{(DST_W-64){1'b0}}, dstMask} << dstOff;
    fieldVal  = {{(DST_W-64){1'b0}}, result} << dstOff;
    destNext  = (destOut & ~fieldMask) | fieldVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcR       <= '0;
      shR        <= '0;
      scalarR    <= '0;
      useScalarR <= 1'b0;
      maskOnR    <= 1'b0;
      maskR      <= '0;
      sewR       <= '0;
      destOut    <= '0;
    end else if (strb.load) begin
      srcR       <= srcVec;
      shR        <= shVec;
      scalarR    <= shScalar;
      useScalarR <= useScalar;
      maskOnR    <= maskOn;
      maskR      <= maskVec;
      sewR       <= sewSel;
      destOut    <= oldDest;
    end else if (strb.write && active) begin
      destOut    <= destNext;
    end
  end

  AST_DEST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load && !strb.write |=> $stable(destOut));  // R5
  AST_DEST_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> destOut == $past(oldDest));  // R7

endmodule

// File: rtl/widen_shl.sv
module widen_shl
  import widen_shl_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  localparam int IDX_W = $clog2(NUM_ELEM + 1),
  localparam int SRC_W = NUM_ELEM * 32,
  localparam int DST_W = NUM_ELEM * 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [SRC_W-1:0]    srcVec,
  input  logic [SRC_W-1:0]    shVec,
  input  logic [63:0]         shScalar,
  input  logic                useScalar,
  input  logic                maskOn,
  input  logic [NUM_ELEM-1:0] maskVec,
  input  logic [1:0]          sewSel,
  input  logic [IDX_W-1:0]    vstartIn,
  input  logic [IDX_W-1:0]    vlIn,
  input  logic [DST_W-1:0]    oldDest,
  output logic [DST_W-1:0]    destOut,
  output logic                done,
  output logic                illegal,
  output logic                dirty,
  output logic [IDX_W-1:0]    vstartOut
);

  ctlStrobe_t       strb;
  logic [IDX_W-1:0] idx;

  widen_shl_ctrl #(.NUM_ELEM(NUM_ELEM)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sewSel(sewSel),
    .vstartIn(vstartIn), .vlIn(vlIn), .strb(strb), .idx(idx),
    .done(done), .illegal(illegal), .dirty(dirty)
  );

  widen_shl_dpath #(.NUM_ELEM(NUM_ELEM)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .idx(idx),
    .srcVec(srcVec), .shVec(shVec), .shScalar(shScalar),
    .useScalar(useScalar), .maskOn(maskOn), .maskVec(maskVec),
    .sewSel(sewSel), .oldDest(oldDest), .destOut(destOut)
  );

  assign vstartOut = idx;

  AST_DIRTY_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    dirty |-> done && vstartOut == '0);  // R9

endmodule

// File: tb/widen_shl_bench.sv
module widen_shl_bench;

  localparam int NE = 8;
  localparam int IW = $clog2(NE + 1);
  localparam int SW = NE * 32;
  localparam int DW = NE * 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [SW-1:0] srcVec = '0, shVec = '0;
  logic [63:0]   shScalar = '0;
  logic          useScalar = 1'b0, maskOn = 1'b1;
  logic [NE-1:0] maskVec = '0;
  logic [1:0]    sewSel = '0;
  logic [IW-1:0] vstartIn = '0, vlIn = '0;
  logic [DW-1:0] oldDest = '0;
  logic [DW-1:0] destOut;
  logic          done, illegal, dirty;
  logic [IW-1:0] vstartOut;

  int nCmp = 0, nBad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  widen_shl #(.NUM_ELEM(NE)) u_widen_shl (
    .clk(clk), .rstN(rstN), .start(start), .srcVec(srcVec), .shVec(shVec),
    .shScalar(shScalar), .useScalar(useScalar), .maskOn(maskOn),
    .maskVec(maskVec), .sewSel(sewSel), .vstartIn(vstartIn), .vlIn(vlIn),
    .oldDest(oldDest), .destOut(destOut), .done(done), .illegal(illegal),
    .dirty(dirty), .vstartOut(vstartOut)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(
    input logic [SW-1:0] s, input logic [SW-1:0] sh, input logic [63:0] sc,
    input bit us, input bit vm, input logic [NE-1:0] m, input int sel,
    input int vs, input int vl, input logic [DW-1:0] od);
    logic [DW-1:0] r;
    longint unsigned a, amt, v;
    int w;
    r = od;
    if (sel == 3) return r;
    w = 8 << sel;
    for (int i = vs; i < vl; i++) begin
      if (vm || m[i]) begin
        a = 0; amt = 0;
        for (int b = 0; b < w; b++) begin
          a[b] = s[i*w+b];
          amt[b] = sh[i*w+b];
        end
        if (us) amt = sc;
        amt = amt % longint'(2*w);
        v = a << amt;
        for (int b = 0; b < 2*w; b++) r[i*2*w+b] = v[b];
      end
    end
    return r;
  endfunction

  function automatic logic [SW-1:0] rndSrc();
    logic [SW-1:0] x;
    for (int k = 0; k < NE; k++) x[k*32 +: 32] = $urandom;
    return x;
  endfunction

  function automatic logic [DW-1:0] rndDst();
    logic [DW-1:0] x;
    for (int k = 0; k < 2*NE; k++) x[k*32 +: 32] = $urandom;
    return x;
  endfunction

  task automatic runOp(input string req, input int sel, input bit us, input logic [63:0] sc,
                       input bit vm, input logic [NE-1:0] m, input int vs, input int vl,
                       input logic [SW-1:0] s, input logic [SW-1:0] sh);
    logic [DW-1:0] od, exp;
    int n, lat;
    od  = rndDst();
    exp = model(s, sh, sc, us, vm, m, sel, vs, vl, od);
    n   = (vl > vs) ? vl - vs : 0;
    lat = (sel == 3) ? 0 : n + 1;
    @(negedge clk);
    srcVec = s; shVec = sh; shScalar = sc; useScalar = us; maskOn = vm;
    maskVec = m; sewSel = 2'(sel); vstartIn = IW'(vs); vlIn = IW'(vl); oldDest = od;
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    if (lat == 0) begin
      check({req, " R7 done"}, DW'(done), DW'(1));
    end else begin
      check({req, " R8 done early"}, DW'(done), DW'(0));
      check({req, " R9 resume index"}, DW'(vstartOut), DW'(vs));
      for (int k = 1; k <= lat; k++) begin
        @(posedge clk);
        #1 check({req, " R8 done timing"}, DW'(done), DW'(k == lat));
      end
    end
    check({req, " dest"}, destOut, exp);
    check({req, " R7 illegal"}, DW'(illegal), DW'(sel == 3));
    check({req, " R9 dirty"}, DW'(dirty), DW'(sel != 3));
    check({req, " R9 vstartOut"}, DW'(vstartOut), DW'(0));
    @(posedge clk);
    #1 check({req, " R8 single pulse"}, DW'(done), DW'(0));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 dest", destOut, '0);
    check("R10 done", DW'(done), DW'(0));
    check("R10 illegal", DW'(illegal), DW'(0));
    check("R10 dirty", DW'(dirty), DW'(0));
    check("R10 vstartOut", DW'(vstartOut), DW'(0));
    rstN = 1'b1;
    @(posedge clk);

    // R1 R3 R4: vector counts at every legal width, full range
    for (int sel = 0; sel < 3; sel++)
      runOp("R1 R3 R4 vector", sel, 0, '0, 1, '0, 0, NE, rndSrc(), rndSrc());
    // R3: scalar count shared by all elements
    for (int sel = 0; sel < 3; sel++)
      runOp("R3 scalar", sel, 1, 64'(3 + sel), 1, '0, 0, NE, rndSrc(), rndSrc());
    // R2: counts at 2*SEW-1, 2*SEW (wraps to 0) and large
    for (int sel = 0; sel < 3; sel++) begin
      runOp("R2 max count", sel, 1, 64'((16 << sel) - 1), 1, '0, 0, NE, rndSrc(), '0);
      runOp("R2 wrap count", sel, 1, 64'(16 << sel), 1, '0, 0, NE, rndSrc(), '0);
      runOp("R2 large count", sel, 1, 64'hFFFF_FFFF_FFFF_FF45, 1, '0, 0, NE, rndSrc(), '0);
    end
    // R1: all-ones source shows zero extension
    runOp("R1 ones", 0, 1, 64'd8, 1, '0, 0, NE, '1, '0);
    runOp("R1 ones", 2, 0, '0, 1, '0, 0, NE, '1, rndSrc());
    // R6: mask applied and ignored
    runOp("R6 masked", 1, 0, '0, 0, 8'b1010_0110, 0, NE, rndSrc(), rndSrc());
    runOp("R6 masked", 0, 1, 64'd5, 0, 8'b0000_0001, 0, NE, rndSrc(), rndSrc());
    runOp("R6 mask ignored", 2, 1, 64'd7, 1, 8'b0000_0000, 0, NE, rndSrc(), rndSrc());
    // R5: partial windows, empty windows
    runOp("R5 window", 0, 0, '0, 1, '0, 2, 5, rndSrc(), rndSrc());
    runOp("R5 window", 2, 1, 64'd33, 1, '0, 3, NE, rndSrc(), rndSrc());
    runOp("R5 empty vl0", 1, 0, '0, 1, '0, 0, 0, rndSrc(), rndSrc());
    runOp("R5 vstart past vl", 1, 0, '0, 1, '0, 6, 4, rndSrc(), rndSrc());
    // R7: illegal width
    runOp("R7 sew64", 3, 0, '0, 1, '0, 0, NE, rndSrc(), rndSrc());
    // mixed random
    for (int t = 0; t < 20; t++) begin
      int sel, vs, vl;
      sel = $urandom_range(0, 3);
      vs  = $urandom_range(0, NE);
      vl  = $urandom_range(0, NE);
      runOp("R1 R5 R6 random", sel, 1'($urandom), 64'($urandom), 1'($urandom),
            NE'($urandom), vs, vl, rndSrc(), rndSrc());
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule